// File: doc/BRIEF.md
# Playfield and Sprite Priority Mixer

This block resolves, for every pixel, which of ten video sources is visible: two playfield layers and eight sprites grouped into four pairs. Each source presents a color index each pixel clock, and an index of zero marks that source transparent. The block returns the winning color index together with a tag that identifies the source that produced it. The result is registered, so the output follows the inputs by one pixel clock.

Software controls the layering through one 16-bit control word. Each playfield has a three-bit slot value that places it among the sprite pairs. A separate bit chooses which playfield lies on top when the two overlap. In single-layer mode (`dual_mode` low), only `pf1_idx` is used as a playfield, and its depth comes from the second slot field. The sprite pairs always keep a fixed order among themselves.

Resolution has two steps. First the visible playfield pixel is chosen from the two layers. Then that pixel is ranked against the sprite pairs using its own slot. This gives a total order in every configuration, including when the two slots differ.

Top module: `pf_sprite_mixer`

## Requirements
- R1: A synchronous active-low reset clears the control word to zero, drives `pix_color` to 0 and `pix_src` to 0, and reads back 0. With the cleared word, playfield 1 lies in front of every sprite and in front of playfield 2.
- R2: In the control word, bits 2:0 give the slot of playfield 1 and bits 5:3 give the slot of playfield 2. Bit 6 set brings playfield 2 in front of playfield 1. Bits 15:7 are discarded on write and read back as 0, and `cfg_rdata` shows the stored bits 6:0.
- R3: Among sprites, a lower-numbered pair is always in front of a higher-numbered pair. Within a pair, the even (lower-numbered) sprite is in front of the odd one.
- R4: A slot value v from 0 to 4 puts the playfield in front of pair v and every pair above it, and behind every pair numbered below v. Value 0 is in front of all sprites, and value 4 is behind all of them.
- R5: Slot values 5, 6 and 7 behave exactly like 4.
- R6: In dual mode, the layer selected by bit 6 wins over the other layer where it is non-transparent; otherwise the other layer shows through. The chosen playfield pixel is then ranked against the sprites by its own slot, so a hidden layer's slot has no effect.
- R7: In single mode, `pf1_idx` is the only playfield and is placed by bits 5:3. `pf2_idx`, bits 2:0 and bit 6 have no effect on the output.
- R8: An index of zero never wins. When every source in use is zero, the output is color 0 with tag 0 (background).
- R9: Pixel inputs sampled at a clock edge appear on the outputs right after that edge. A control write taken at an edge governs the pixels sampled from the next edge on.
- R10: `pix_src` is 0 for background, 1 for playfield 1, 2 for playfield 2, and 8+n for sprite n. `pix_color` equals the winning source's input index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Stored control word |
| dual_mode | input | 1 | 1 = two playfield layers, 0 = single layer |
| pf1_idx | input | CW (4) | Playfield 1 color index, 0 = transparent |
| pf2_idx | input | CW (4) | Playfield 2 color index, 0 = transparent |
| spr_idx | input | 2*NPAIR*CW (32) | Sprite color indices, sprite n at bits n*CW +: CW |
| pix_color | output | CW (4) | Registered winning color index |
| pix_src | output | 4 | Registered source tag of the winner |

## Verification
The embedded assertions watch, on every cycle, that a fully transparent input gives the background, and that a zero color always pairs with the background tag. They also check that sprite 0 beats any playfield pushed behind pair 0, that playfield 1 at slot 0 wins when it has the front bit, that single mode never reports playfield 2, and that control writes read back with the upper bits zero. Only the directed scenarios can show the rest: the full slot-against-pair ordering, the clamping of slot values above 4, the interaction of the front bit with unequal slots, and the timing of a control write against the pixel stream. A seeded sweep compares many random mixes against an order model built from the requirements.

// File: rtl/pfmix_pkg.sv
package pfmix_pkg;

    localparam int TAG_W   = 4;
    localparam int CFG_W   = 16;
    localparam int FIELD_W = 3;
    localparam int USED_W  = 7;

    // field positions inside the control word
    localparam int PF1_LSB   = 0;
    localparam int PF2_LSB   = 3;
    localparam int FRONT_BIT = 6;

    typedef logic [TAG_W-1:0] src_tag_t;

    localparam src_tag_t TAG_BG       = 4'd0;
    localparam src_tag_t TAG_PF1      = 4'd1;
    localparam src_tag_t TAG_PF2      = 4'd2;
    localparam src_tag_t TAG_SPR_BASE = 4'd8;

    // slot values past the last pair collapse onto "behind everything"
    function automatic logic [FIELD_W-1:0] clamp_slot(input logic [FIELD_W-1:0] v,
                                                      input int last);
        return (int'(v) > last) ? FIELD_W'(last) : v;
    endfunction

endpackage

// File: rtl/mix_ctrl_reg.sv
module mix_ctrl_reg
    import pfmix_pkg::*;
#(
    parameter int NPAIR = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CFG_W-1:0]   wdata,
    output logic [CFG_W-1:0]   rdata,
    output logic [FIELD_W-1:0] pf1_slot,
    output logic [FIELD_W-1:0] pf2_slot,
    output logic               pf2_front
);

    logic [USED_W-1:0] ctl_q;
    logic              hi_bits_unused;

    assign hi_bits_unused = ^wdata[CFG_W-1:USED_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= wdata[USED_W-1:0];
        end
    end

    assign rdata     = {{(CFG_W-USED_W){1'b0}}, ctl_q};
    assign pf1_slot  = clamp_slot(ctl_q[PF1_LSB +: FIELD_W], NPAIR);
    assign pf2_slot  = clamp_slot(ctl_q[PF2_LSB +: FIELD_W], NPAIR);
    assign pf2_front = ctl_q[FRONT_BIT];

    // R2: a write is visible on the read port one edge later, upper bits zero
    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (rdata[USED_W-1:0] == $past(wdata[USED_W-1:0])) &&
               (rdata[CFG_W-1:USED_W] == '0));

    // R1: reset leaves a cleared control word
    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

endmodule

// File: rtl/mix_pair_pick.sv
module mix_pair_pick
    import pfmix_pkg::*;
#(
    parameter int CW    = 4,
    parameter int NPAIR = 4
) (
    input  logic [2*NPAIR*CW-1:0]          spr_idx,
    output logic [NPAIR-1:0][CW-1:0]       pair_col,
    output logic [NPAIR-1:0][TAG_W-1:0]    pair_tag
);

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        localparam int LO = 2 * p;
        localparam int HI = 2 * p + 1;

        logic [CW-1:0] lo_c;
        logic [CW-1:0] hi_c;

        assign lo_c = spr_idx[LO*CW +: CW];
        assign hi_c = spr_idx[HI*CW +: CW];

        // even sprite sits in front of its odd partner
        assign pair_col[p] = (lo_c != '0) ? lo_c : hi_c;
        assign pair_tag[p] = (lo_c != '0) ? TAG_SPR_BASE + TAG_W'(LO) :
                             (hi_c != '0) ? TAG_SPR_BASE + TAG_W'(HI) : TAG_BG;
    end

endmodule

// File: rtl/mix_layer_resolve.sv
module mix_layer_resolve
    import pfmix_pkg::*;
#(
    parameter int CW    = 4,
    parameter int NPAIR = 4
) (
    input  logic                        dual_mode,
    input  logic [CW-1:0]               pf1_idx,
    input  logic [CW-1:0]               pf2_idx,
    input  logic [FIELD_W-1:0]          pf1_slot,
    input  logic [FIELD_W-1:0]          pf2_slot,
    input  logic                        pf2_front,
    input  logic [NPAIR-1:0][CW-1:0]    pair_col,
    input  logic [NPAIR-1:0][TAG_W-1:0] pair_tag,
    output logic [CW-1:0]               win_col,
    output logic [TAG_W-1:0]            win_tag
);

    localparam int NSTAGE = NPAIR + 1;

    logic [CW-1:0]      pf_col;
    logic [TAG_W-1:0]   pf_tag;
    logic [FIELD_W-1:0] pf_slot;

    // step one: which playfield pixel is on top
    always_comb begin
        if (!dual_mode) begin
            pf_col  = pf1_idx;
            pf_tag  = TAG_PF1;
            pf_slot = pf2_slot;
        end else if (pf2_front) begin
            if (pf2_idx != '0) begin
                pf_col  = pf2_idx;
                pf_tag  = TAG_PF2;
                pf_slot = pf2_slot;
            end else begin
                pf_col  = pf1_idx;
                pf_tag  = TAG_PF1;
                pf_slot = pf1_slot;
            end
        end else begin
            if (pf1_idx != '0) begin
                pf_col  = pf1_idx;
                pf_tag  = TAG_PF1;
                pf_slot = pf1_slot;
            end else begin
                pf_col  = pf2_idx;
                pf_tag  = TAG_PF2;
                pf_slot = pf2_slot;
            end
        end
    end

    // step two: back-to-front chain, stage g covers pairs >= g and slots >= g
    logic [NSTAGE:0][CW-1:0]    ch_col;
    logic [NSTAGE:0][TAG_W-1:0] ch_tag;

    assign ch_col[NSTAGE] = '0;
    assign ch_tag[NSTAGE] = TAG_BG;

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        logic [CW-1:0]    mid_col;
        logic [TAG_W-1:0] mid_tag;
        logic             pf_here;

        if (g < NPAIR) begin : g_with_pair
            assign mid_col = (pair_col[g] != '0) ? pair_col[g] : ch_col[g+1];
            assign mid_tag = (pair_col[g] != '0) ? pair_tag[g] : ch_tag[g+1];
        end else begin : g_floor
            assign mid_col = ch_col[g+1];
            assign mid_tag = ch_tag[g+1];
        end

        assign pf_here   = (pf_col != '0) && (pf_slot == FIELD_W'(g));
        assign ch_col[g] = pf_here ? pf_col : mid_col;
        assign ch_tag[g] = pf_here ? pf_tag : mid_tag;
    end

    assign win_col = ch_col[0];
    assign win_tag = ch_tag[0];

endmodule

// File: rtl/pf_sprite_mixer.sv
module pf_sprite_mixer
    import pfmix_pkg::*;
#(
    parameter int CW    = 4,
    parameter int NPAIR = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_we,
    input  logic [15:0]           cfg_wdata,
    output logic [15:0]           cfg_rdata,
    input  logic                  dual_mode,
    input  logic [CW-1:0]         pf1_idx,
    input  logic [CW-1:0]         pf2_idx,
    input  logic [2*NPAIR*CW-1:0] spr_idx,
    output logic [CW-1:0]         pix_color,
    output logic [3:0]            pix_src
);

    logic [FIELD_W-1:0]          pf1_slot;
    logic [FIELD_W-1:0]          pf2_slot;
    logic                        pf2_front;
    logic [NPAIR-1:0][CW-1:0]    pair_col;
    logic [NPAIR-1:0][TAG_W-1:0] pair_tag;
    logic [CW-1:0]               win_col;
    logic [TAG_W-1:0]            win_tag;

    mix_ctrl_reg #(.NPAIR(NPAIR)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .pf1_slot  (pf1_slot),
        .pf2_slot  (pf2_slot),
        .pf2_front (pf2_front)
    );

    mix_pair_pick #(.CW(CW), .NPAIR(NPAIR)) u_pairs (
        .spr_idx  (spr_idx),
        .pair_col (pair_col),
        .pair_tag (pair_tag)
    );

    mix_layer_resolve #(.CW(CW), .NPAIR(NPAIR)) u_resolve (
        .dual_mode (dual_mode),
        .pf1_idx   (pf1_idx),
        .pf2_idx   (pf2_idx),
        .pf1_slot  (pf1_slot),
        .pf2_slot  (pf2_slot),
        .pf2_front (pf2_front),
        .pair_col  (pair_col),
        .pair_tag  (pair_tag),
        .win_col   (win_col),
        .win_tag   (win_tag)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_color <= '0;
            pix_src   <= TAG_BG;
        end else begin
            pix_color <= win_col;
            pix_src   <= win_tag;
        end
    end

    logic          all_clear;
    logic [CW-1:0] spr0_idx;

    assign all_clear = (pf1_idx == '0) && (pf2_idx == '0) && (spr_idx == '0);
    assign spr0_idx  = spr_idx[CW-1:0];

    // R8: nothing opaque in, background out
    assert_bg_when_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        all_clear |=> (pix_color == '0) && (pix_src == TAG_BG));

    // R10: a zero color only ever travels with the background tag
    assert_tag_color_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_color == '0) == (pix_src == TAG_BG));

    // R3: sprite 0 beats any playfield set behind pair 0
    assert_spr0_front_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && spr0_idx != '0 && pf1_slot != '0 && pf2_slot != '0)
        |=> (pix_src == TAG_SPR_BASE) && (pix_color == $past(spr0_idx)));

    // R4: playfield 1 at slot 0 with the front choice wins outright
    assert_pf1_slot0_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && !pf2_front && pf1_slot == '0 && pf1_idx != '0)
        |=> (pix_src == TAG_PF1) && (pix_color == $past(pf1_idx)));

    // R7: single-layer mode never reports playfield 2
    assert_single_no_pf2_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dual_mode |=> (pix_src != TAG_PF2));

endmodule

// File: tb/sim_pf_sprite_mixer.sv
module sim_pf_sprite_mixer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        dual_mode = 1'b1;
    logic [3:0]  pf1_idx = '0;
    logic [3:0]  pf2_idx = '0;
    logic [31:0] spr_idx = '0;
    logic [3:0]  pix_color;
    logic [3:0]  pix_src;

    int n_chk  = 0;
    int n_fail = 0;
    logic [6:0] shadow = '0;

    always #10 clk = ~clk;

    pf_sprite_mixer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .dual_mode (dual_mode),
        .pf1_idx   (pf1_idx),
        .pf2_idx   (pf2_idx),
        .spr_idx   (spr_idx),
        .pix_color (pix_color),
        .pix_src   (pix_src)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_pix(input string req, input int tag, input int col);
        chk(req, "pix_src", int'(pix_src), tag);
        chk(req, "pix_color", int'(pix_color), col);
    endtask

    // called at a falling edge, returns at the next falling edge
    task automatic wr(input logic [15:0] v);
        cfg_we    = 1'b1;
        cfg_wdata = v;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        shadow = v[6:0];
    endtask

    task automatic px(input logic [3:0] a, input logic [3:0] b, input logic [31:0] s);
        pf1_idx = a;
        pf2_idx = b;
        spr_idx = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] one_spr(input int n, input logic [3:0] c);
        return {28'd0, c} << (4 * n);
    endfunction

    // order model: smaller key is nearer the viewer
    function automatic logic [7:0] model(input logic [6:0] r, input logic dm,
                                         input logic [3:0] a, input logic [3:0] b,
                                         input logic [31:0] s);
        int         best;
        int         slot;
        logic [7:0] res;
        logic [3:0] pc;
        logic [3:0] pt;
        logic [2:0] f1;
        logic [2:0] f2;
        best = 1000;
        res  = 8'h00;
        f1 = (r[2:0] > 3'd4) ? 3'd4 : r[2:0];
        f2 = (r[5:3] > 3'd4) ? 3'd4 : r[5:3];
        for (int n = 0; n < 8; n++) begin
            logic [3:0] c;
            int k;
            c = s[n*4 +: 4];
            k = (n / 2) * 8 + 4 + (n % 2);
            if (c != 4'd0 && k < best) begin
                best = k;
                res  = {4'(8 + n), c};
            end
        end
        if (!dm) begin
            pc = a; pt = 4'd1; slot = int'(f2);
        end else if (r[6] ? (b != 4'd0) : (a == 4'd0)) begin
            pc = b; pt = 4'd2; slot = int'(f2);
        end else begin
            pc = a; pt = 4'd1; slot = int'(f1);
        end
        if (pc != 4'd0 && slot * 8 < best) res = {pt, pc};
        return res;
    endfunction

    task automatic t_reset_state;
        chk("R1", "rdata in reset", int'(cfg_rdata), 0);
        chk_pix("R1", 0, 0);
    endtask

    task automatic t_regmap;
        wr(16'hFFFF);
        chk("R2", "upper bits dropped", int'(cfg_rdata), 16'h007F);
        wr(16'hFF80);
        chk("R2", "only upper bits written", int'(cfg_rdata), 0);
        wr(16'h0055);
        chk("R2", "readback", int'(cfg_rdata), 16'h0055);
    endtask

    task automatic t_sprites;
        dual_mode = 1'b1;
        wr(16'h0024);
        px(4'd0, 4'd0, 32'h87654321);
        chk_pix("R3 all sprites", 8, 1);
        px(4'd0, 4'd0, one_spr(1, 4'd2) | one_spr(3, 4'd4));
        chk_pix("R3 odd pair0 over pair1", 9, 2);
        px(4'd0, 4'd0, one_spr(6, 4'd5) | one_spr(7, 4'd7));
        chk_pix("R3 even over odd", 14, 5);
        px(4'd0, 4'd0, one_spr(5, 4'd3) | one_spr(7, 4'd6));
        chk_pix("R3 pair2 over pair3", 13, 3);
        px(4'd0, 4'd0, one_spr(3, 4'd9) | one_spr(4, 4'd1));
        chk_pix("R3 odd pair1 over even pair2", 11, 9);
    endtask

    task automatic t_place;
        dual_mode = 1'b1;
        for (int v = 0; v < 5; v++) begin
            wr(16'(v));
            for (int q = 0; q < 4; q++) begin
                px(4'd9, 4'd0, one_spr(2 * q + 1, 4'd6));
                if (v <= q) chk_pix("R4 playfield ahead", 1, 9);
                else        chk_pix("R4 pair ahead", 8 + 2 * q + 1, 6);
            end
        end
    endtask

    task automatic t_clamp;
        dual_mode = 1'b1;
        for (int v = 5; v < 8; v++) begin
            wr(16'(v));
            px(4'd9, 4'd0, one_spr(7, 4'd3));
            chk_pix("R5 pf1 behind last sprite", 15, 3);
            px(4'd9, 4'd0, 32'd0);
            chk_pix("R5 pf1 over background", 1, 9);
            wr(16'h0040 | 16'(v << 3));
            px(4'd0, 4'd8, one_spr(7, 4'd2));
            chk_pix("R5 pf2 behind last sprite", 15, 2);
        end
    endtask

    task automatic t_pf2pri;
        dual_mode = 1'b1;
        wr(16'h0012);
        px(4'd3, 4'd4, 32'd0);
        chk_pix("R6 pf1 default front", 1, 3);
        wr(16'h0052);
        px(4'd3, 4'd4, 32'd0);
        chk_pix("R6 pf2 front bit", 2, 4);
        px(4'd3, 4'd0, 32'd0);
        chk_pix("R6 pf1 through clear pf2", 1, 3);
        wr(16'h000B);
        px(4'd3, 4'd4, one_spr(2, 4'd6));
        chk_pix("R6 chosen pf1 uses slot 3", 10, 6);
        wr(16'h004B);
        px(4'd3, 4'd4, one_spr(2, 4'd6));
        chk_pix("R6 chosen pf2 uses slot 1", 2, 4);
    endtask

    task automatic t_single;
        dual_mode = 1'b0;
        wr(16'h0020);
        px(4'd5, 4'd0, one_spr(7, 4'd2));
        chk_pix("R7 slot from bits 5:3", 15, 2);
        px(4'd5, 4'd7, 32'd0);
        chk_pix("R7 pf2 ignored", 1, 5);
        px(4'd0, 4'd7, 32'd0);
        chk_pix("R7 pf2 never shows", 0, 0);
        wr(16'h0004);
        px(4'd5, 4'd0, one_spr(0, 4'd2));
        chk_pix("R7 bits 2:0 ignored", 1, 5);
        wr(16'h0044);
        px(4'd5, 4'd7, one_spr(0, 4'd2));
        chk_pix("R7 bit 6 ignored", 1, 5);
        px(4'd0, 4'd7, one_spr(6, 4'd1));
        chk_pix("R7 sprite over hidden pf2", 14, 1);
        dual_mode = 1'b1;
    endtask

    task automatic t_transp;
        dual_mode = 1'b1;
        wr(16'h0000);
        px(4'd0, 4'd0, 32'd0);
        chk_pix("R8 all clear", 0, 0);
        px(4'd0, 4'd0, one_spr(7, 4'd3));
        chk_pix("R8 clear pf1 does not block", 15, 3);
        px(4'd0, 4'd6, 32'd0);
        chk_pix("R8 pf2 behind clear pf1", 2, 6);
        px(4'd15, 4'd0, 32'd0);
        chk_pix("R10 pf1 tag and color", 1, 15);
    endtask

    task automatic t_timing;
        dual_mode = 1'b1;
        wr(16'h0000);
        px(4'd5, 4'd0, one_spr(7, 4'd3));
        chk_pix("R9 slot 0 before write", 1, 5);
        cfg_we    = 1'b1;
        cfg_wdata = 16'h0004;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        shadow = 7'h04;
        chk_pix("R9 write edge still old order", 1, 5);
        @(posedge clk);
        @(negedge clk);
        chk_pix("R9 next pixel new order", 15, 3);
        pf1_idx = '0;
        spr_idx = '0;
        #5;
        chk_pix("R9 output held until edge", 15, 3);
        @(posedge clk);
        @(negedge clk);
        chk_pix("R9 output after edge", 0, 0);
    endtask

    task automatic t_midreset;
        dual_mode = 1'b1;
        wr(16'h007F);
        px(4'd3, 4'd0, 32'd0);
        chk_pix("R1 before reset", 1, 3);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1", "rdata after reset", int'(cfg_rdata), 0);
        chk_pix("R1 outputs in reset", 0, 0);
        rst_n  = 1'b1;
        shadow = '0;
        px(4'd3, 4'd4, one_spr(0, 4'd5));
        chk_pix("R1 pf1 front after reset", 1, 3);
    endtask

    task automatic t_sweep;
        logic [31:0] st;
        logic [7:0]  e;
        st = 32'h1F2E3D4C;
        for (int i = 0; i < 400; i++) begin
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            if (i % 5 == 0) wr({9'd0, st[6:0]});
            dual_mode = st[7];
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            pf1_idx = st[3:0] & {4{st[4]}};
            pf2_idx = st[11:8] & {4{st[12]}};
            spr_idx = st;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            spr_idx = spr_idx & st;
            st = st ^ (st << 13); st = st ^ (st >> 17); st = st ^ (st << 5);
            spr_idx = spr_idx & st;
            e = model(shadow, dual_mode, pf1_idx, pf2_idx, spr_idx);
            @(posedge clk);
            @(negedge clk);
            chk_pix("R3/R4/R6 sweep", int'(e[7:4]), int'(e[3:0]));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        t_regmap();
        t_sprites();
        t_place();
        t_clamp();
        t_pf2pri();
        t_single();
        t_transp();
        t_timing();
        t_midreset();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule